// File: doc/BRIEF.md
# Reference-Compare Timer with Request Steering

This block is an up-counting timer for general use. Software configures it through a small word-wide register port. A mode register picks the tick source for the counter. The source can be stopped, every system clock, one system clock in sixteen, or each falling edge on an external pin. The counter is compared with a programmable reference value on every tick.

When the next count would equal the reference, a match occurs. The match sets a sticky event flag. It also acts on an output pin: either a one-cycle low pulse or a change of level. A reference-reached request is raised when the flag goes from clear to set and requests are enabled. A steering bit sends that request to a DMA request line, which is held until acknowledged, or to a level interrupt. After a match the counter either runs on or returns to zero.

A run bit holds the whole timer in a software reset while it is low. During that time the other mode fields stay writable. Two small state machines shape the behaviour. The core machine has the states HALT and RUN. It moves HALT to RUN when the run bit goes high (transition "start"). It moves RUN to HALT when the run bit goes low (transition "reinit"); that transition clears the counter, the flag, the toggle level and any pending DMA request. The request machine has the states RQ_IDLE and RQ_PEND. It moves RQ_IDLE to RQ_PEND on a steered DMA request ("raise"). It moves RQ_PEND to RQ_IDLE on an acknowledge or on reinit ("ack").

Top module: `ref_timer`

## Requirements
- R1: In pulse mode (mode bit 4 = 0), `tmr_out` idles high and is low for exactly the one clock cycle that follows each match edge.
- R2: In toggle mode (mode bit 4 = 1), `tmr_out` inverts on every match edge. It returns to high whenever the timer is held in software reset.
- R3: The request-enable bit (mode bit 5) gates the request. The steering bit (mode bit 6) selects the line: 1 raises `dma_req`, 0 raises `irq`. The other line stays low.
- R4: With mode bit 3 = 1, the counter counts 1..ref-1 and then returns to 0 on the match tick, so after n ticks it reads n mod ref. With mode bit 3 = 0, it keeps counting past the reference.
- R5: Mode bits 2:1 select the tick source: 00 stopped (counter holds), 01 every clock, 10 one clock in sixteen, 11 falling edges on `ext_in`.
- R6: The divide-by-16 prescaler runs freely and is not reset by the run bit. Any 160 consecutive clocks therefore give exactly 10 ticks.
- R7: While the run bit (mode bit 0) is 0, the counter reads 0 and does not advance, and the mode fields remain writable and readable. A 1-to-0 change of the run bit clears the event flag.
- R8: The event flag (address 3, bit 0) is set by a match. Writing 1 to it clears it, and writing 0 leaves it unchanged. `irq` is the level flag AND enable AND NOT steering.
- R9: `dma_req` stays high from its rise until `dma_ack` is sampled high. It rises only when the flag goes from 0 to 1, so a match that finds the flag already set raises nothing.
- R10: `ext_in` passes through a two-stage synchroniser. Each high-to-low change advances the counter by one, and rising changes do not advance it.
- R11: After reset, the mode, reference, counter and flag read 0, `tmr_out` is 1, and `irq` and `dma_req` are 0.
- R12: Register addresses are 0 mode (bits 6:0), 1 reference, 2 counter (read-only) and 3 event flag. A write lands on the clock edge, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 2 | Register select for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the selected register |
| ext_in | input | 1 | External tick input, counted on falling edges |
| tmr_out | output | 1 | Timer output pin, pulse or toggle |
| irq | output | 1 | Reference-reached interrupt level |
| dma_ack | input | 1 | Acknowledge that clears the DMA request |
| dma_req | output | 1 | Reference-reached DMA request |

## Verification
The bench builds the block with its default values: a 32-bit counter, a prescaler of 16 and a two-stage synchroniser. With a prescaler of 16, a 160-cycle window checks the exact tick rate. References of 2 to 40 let the random passes cover many restart periods and both output modes within a few thousand clocks. Counter wrap at 2^32 is beyond the window at this width, so only reference matches below the wrap are exercised.

// File: rtl/ref_timer_pkg.sv
package ref_timer_pkg;
    typedef enum logic [1:0] {
        SRC_STOP = 2'b00,
        SRC_CLK  = 2'b01,
        SRC_DIV  = 2'b10,
        SRC_EXT  = 2'b11
    } src_e;

    typedef struct packed {
        logic steer_dma;
        logic req_en;
        logic toggle;
        logic restart;
        src_e src;
        logic run;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_MODE = 2'd0;
    localparam logic [ADDR_W-1:0] A_REF  = 2'd1;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd2;
    localparam logic [ADDR_W-1:0] A_EVT  = 2'd3;
endpackage

// File: rtl/ref_timer_tick.sv
module ref_timer_tick
    import ref_timer_pkg::*;
#(
    parameter int PRESC_DIV   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  src_e src,
    input  logic ext_in,
    output logic tick
);
    logic div_tick;
    logic ext_fall;

    generate
        if (PRESC_DIV < 2) begin : g_nodiv
            assign div_tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(PRESC_DIV);
            logic [PW-1:0] pre_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                          pre_q <= '0;
                else if (pre_q == PW'(PRESC_DIV-1))  pre_q <= '0;
                else                                 pre_q <= pre_q + 1'b1;
            end
            assign div_tick = (pre_q == PW'(PRESC_DIV-1));
        end
    endgenerate

    // synchroniser stages plus one history stage for edge detection
    logic [SYNC_STAGES:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[SYNC_STAGES-1:0], ext_in};
    end
    assign ext_fall = sh_q[SYNC_STAGES] & ~sh_q[SYNC_STAGES-1];

    always_comb begin
        unique case (src)
            SRC_STOP: tick = 1'b0;
            SRC_CLK:  tick = 1'b1;
            SRC_DIV:  tick = div_tick;
            SRC_EXT:  tick = ext_fall;
            default:  tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/ref_timer_core.sv
module ref_timer_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             toggle,
    input  logic             tick,
    input  logic [CNT_W-1:0] ref_val,
    output logic [CNT_W-1:0] cnt,
    output logic             hit,
    output logic             reinit,
    output logic             tmr_out
);
    typedef enum logic {ST_HALT, ST_RUN} core_st_e;
    core_st_e st_q, st_d;

    logic [CNT_W-1:0] next_cnt;
    logic             pulse_q;
    logic             tog_q;

    assign next_cnt = cnt + 1'b1;
    assign hit      = run && tick && (next_cnt == ref_val);

    always_comb begin
        st_d   = st_q;
        reinit = 1'b0;
        unique case (st_q)
            ST_HALT: if (run)  st_d = ST_RUN;
            ST_RUN:  if (!run) begin st_d = ST_HALT; reinit = 1'b1; end
            default: st_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HALT;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            pulse_q <= 1'b1;
            tog_q   <= 1'b1;
        end else begin
            pulse_q <= !(hit && !toggle);
            if (!run) begin
                cnt   <= '0;
                tog_q <= 1'b1;
            end else if (tick) begin
                cnt <= (hit && restart) ? '0 : next_cnt;
                if (hit) tog_q <= ~tog_q;
            end
        end
    end

    assign tmr_out = toggle ? tog_q : pulse_q;

    p_pulse_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_q && !hit) |=> pulse_q);
    p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && restart) |=> (cnt == '0));
    p_stop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ((cnt == $past(cnt)) || (cnt == '0)));
    p_halt_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/ref_timer_req.sv
module ref_timer_req (
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    input  logic raise,
    input  logic req_en,
    input  logic steer_dma,
    input  logic reinit,
    input  logic dma_ack,
    output logic irq,
    output logic dma_req
);
    typedef enum logic {RQ_IDLE, RQ_PEND} req_st_e;
    req_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RQ_IDLE: if (raise && req_en && steer_dma && !reinit) st_d = RQ_PEND;
            RQ_PEND: if (dma_ack || reinit) st_d = RQ_IDLE;
            default: st_d = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RQ_IDLE;
        else        st_q <= st_d;
    end

    assign dma_req = (st_q == RQ_PEND);
    assign irq     = flag && req_en && !steer_dma;

    p_dma_steer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> $past(steer_dma && req_en));
    p_irq_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !dma_req || !steer_dma);
    p_dma_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack && !reinit) |=> dma_req);
endmodule

// File: rtl/ref_timer.sv
module ref_timer
    import ref_timer_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int PRESC_DIV   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    input  logic             ext_in,
    output logic             tmr_out,
    output logic             irq,
    input  logic             dma_ack,
    output logic             dma_req
);
    mode_t            mode_q;
    logic [CNT_W-1:0] ref_q;
    logic [CNT_W-1:0] cnt;
    logic             flag_q;
    logic             tick, hit, reinit, raise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            ref_q  <= '0;
        end else if (wr_en) begin
            if (addr == A_MODE) mode_q <= mode_t'(wr_data[MODE_W-1:0]);
            if (addr == A_REF)  ref_q  <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 flag_q <= 1'b0;
        else if (reinit)                            flag_q <= 1'b0;
        else if (hit)                               flag_q <= 1'b1;
        else if (wr_en && addr == A_EVT && wr_data[0]) flag_q <= 1'b0;
    end

    assign raise = hit && !flag_q;

    always_comb begin
        unique case (addr)
            A_MODE:  rd_data = CNT_W'(mode_q);
            A_REF:   rd_data = ref_q;
            A_CNT:   rd_data = cnt;
            A_EVT:   rd_data = CNT_W'(flag_q);
            default: rd_data = '0;
        endcase
    end

    ref_timer_tick #(.PRESC_DIV(PRESC_DIV), .SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk(clk), .rst_n(rst_n), .src(mode_q.src), .ext_in(ext_in), .tick(tick)
    );

    ref_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run(mode_q.run), .restart(mode_q.restart),
        .toggle(mode_q.toggle), .tick(tick), .ref_val(ref_q), .cnt(cnt),
        .hit(hit), .reinit(reinit), .tmr_out(tmr_out)
    );

    ref_timer_req u_req (
        .clk(clk), .rst_n(rst_n), .flag(flag_q), .raise(raise),
        .req_en(mode_q.req_en), .steer_dma(mode_q.steer_dma), .reinit(reinit),
        .dma_ack(dma_ack), .irq(irq), .dma_req(dma_req)
    );

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !reinit && !(wr_en && addr == A_EVT && wr_data[0])) |=> flag_q);
    p_flag_on_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_q);
endmodule

// File: tb/ref_timer_tb_top.sv
module ref_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ext_in = 1'b1;
    logic        tmr_out, irq, dma_req;
    logic        dma_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ref_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .ext_in(ext_in), .tmr_out(tmr_out), .irq(irq),
        .dma_ack(dma_ack), .dma_req(dma_req)
    );

    function automatic logic [31:0] mk(bit run, bit [1:0] src, bit rs, bit tg, bit ren, bit dm);
        return {25'd0, dm, ren, tg, rs, src, run};
    endfunction

    function automatic int exp_cnt(int n, int r, bit rs);
        return rs ? (n % r) : n;
    endfunction

    function automatic bit exp_tog(int n, int r, bit rs);
        int m;
        m = rs ? (n / r) : ((n >= r) ? 1 : 0);
        return ~m[0];
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        addr = a;
        #1 v = rd_data;
    endtask

    task automatic step(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic setup(int r);
        wr(2'd0, 32'd0);
        wr(2'd1, r);
        wr(2'd3, 32'd1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'd2024));
        step(3);
        rst_n = 1'b1;
        step(1);

        // R11 reset state
        rd(2'd0, v); check(v == 0, "R11 mode", v, 0);
        rd(2'd1, v); check(v == 0, "R11 ref", v, 0);
        rd(2'd2, v); check(v == 0, "R11 cnt", v, 0);
        rd(2'd3, v); check(v == 0, "R11 flag", v, 0);
        check(tmr_out == 1 && irq == 0 && dma_req == 0, "R11 pins", {tmr_out, irq, dma_req}, 3'b100);

        // R4 free run past reference, R12 counter read
        setup(4);
        wr(2'd0, mk(1, 2'b01, 0, 0, 0, 0));
        step(10);
        rd(2'd2, v); check(v == 10, "R4 free-run count", v, 10);
        rd(2'd3, v); check(v[0] == 1, "R8 flag set", v[0], 1);

        // R5 stop source holds count
        setup(100);
        wr(2'd0, mk(1, 2'b01, 0, 0, 0, 0));
        step(5);
        wr(2'd0, mk(1, 2'b00, 0, 0, 0, 0));
        step(10);
        rd(2'd2, v); check(v == 6, "R5 stop hold", v, 6);

        // R7 halt: counter zero, fields writable, flag cleared
        wr(2'd0, mk(1, 2'b01, 0, 1, 0, 0));
        step(200);
        wr(2'd0, mk(0, 2'b01, 1, 1, 1, 1));
        step(5);
        rd(2'd2, v); check(v == 0, "R7 halt count", v, 0);
        rd(2'd3, v); check(v[0] == 0, "R7 flag reinit", v[0], 0);
        rd(2'd0, v); check(v == mk(0, 2'b01, 1, 1, 1, 1), "R7 mode readable", v, mk(0, 2'b01, 1, 1, 1, 1));
        check(tmr_out == 1, "R2 toggle reset high", tmr_out, 1);

        // R1 pulse mode
        setup(6);
        wr(2'd0, mk(1, 2'b01, 1, 0, 0, 0));
        step(5);  check(tmr_out == 1, "R1 before match", tmr_out, 1);
        step(1);  check(tmr_out == 0, "R1 pulse low", tmr_out, 0);
        step(1);  check(tmr_out == 1, "R1 pulse end", tmr_out, 1);

        // R6 divide by 16
        setup(32'hFFFF_0000);
        wr(2'd0, mk(1, 2'b10, 0, 0, 0, 0));
        step(160);
        rd(2'd2, v); check(v == 10, "R6 div16 ticks", v, 10);

        // R10 external falling edges
        setup(32'hFFFF_0000);
        wr(2'd0, mk(1, 2'b11, 0, 0, 0, 0));
        for (int i = 0; i < 5; i++) begin
            ext_in = 1'b0; step(3);
            ext_in = 1'b1; step(3);
        end
        step(3);
        rd(2'd2, v); check(v == 5, "R10 ext edges", v, 5);

        // R9 / R3 DMA steering
        setup(3);
        wr(2'd0, mk(1, 2'b01, 1, 0, 1, 1));
        step(3);
        check(dma_req == 1 && irq == 0, "R3 dma steered", {dma_req, irq}, 2'b10);
        step(4);  check(dma_req == 1, "R9 dma held", dma_req, 1);
        dma_ack = 1'b1; step(1); dma_ack = 1'b0;
        check(dma_req == 0, "R9 dma ack", dma_req, 0);
        step(2);  check(dma_req == 0, "R9 no rerequest with flag set", dma_req, 0);
        wr(2'd3, 32'd1);
        rd(2'd3, v); check(v[0] == 0, "R8 clear by one", v[0], 0);
        step(1);  check(dma_req == 1, "R9 new request", dma_req, 1);

        // R8 / R3 interrupt steering
        setup(5);
        wr(2'd0, mk(1, 2'b01, 1, 0, 1, 0));
        step(4);  check(irq == 0, "R8 irq before", irq, 0);
        step(1);  check(irq == 1 && dma_req == 0, "R3 irq steered", {irq, dma_req}, 2'b10);
        wr(2'd3, 32'd0);
        check(irq == 1, "R8 write zero ignored", irq, 1);
        wr(2'd3, 32'd1);
        check(irq == 0, "R8 clear drops irq", irq, 0);
        step(3);  check(irq == 1, "R8 irq again", irq, 1);

        // random passes: R4, R2, R3, R8
        for (int it = 0; it < 12; it++) begin
            int r, nn;
            bit rs, ren;
            r   = $urandom_range(40, 2);
            nn  = $urandom_range(120, 1);
            rs  = $urandom_range(1, 0);
            ren = $urandom_range(1, 0);
            setup(r);
            wr(2'd0, mk(1, 2'b01, rs, 1, ren, 0));
            step(nn);
            rd(2'd2, v); check(v == exp_cnt(nn, r, rs), "R4 random count", v, exp_cnt(nn, r, rs));
            check(tmr_out == exp_tog(nn, r, rs), "R2 random toggle", tmr_out, exp_tog(nn, r, rs));
            check(irq == (ren && nn >= r), "R3 random irq gate", irq, (ren && nn >= r));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule